// File: doc/BRIEF.md
# Programmable Down-Counting Event Timer

This block is a small register-mapped timer with a 16-bit down-counter. Software writes a start value and a control word over a simple synchronous register bus. Once enabled, the counter steps down once per prescaler tick. A tick comes on every clock, or on every 16th or every 256th clock. When the count runs out, the block raises a level interrupt. In periodic mode the counter then restarts from the stored start value. In single-shot mode it parks at zero and switches itself off.

The live count can be read at any moment. Because the count runs downward, software can negate it to obtain a rising timebase. The interrupt stays asserted until software writes any value to the clear register. To reprogram the timer, software disables it, writes a new start value, and enables it again. Disabling keeps the mode and prescale settings.

The bus decodes the word index `bus_addr[4:2]`:
- index 0: start value.
- index 1: live count, read-only.
- index 2: control word.
- index 3: interrupt clear, write-only.
- index 4: raw interrupt status.

Top module: `down_timer`

## Requirements
- R1: After reset the control word, the live count and the interrupt are all zero, and the timer is not counting.
- R2: The control word reads back enable on bit 7, periodic on bit 6 and the prescale code on bits 3:2. All other bits read zero.
- R3: While the timer is disabled, a write to the start value (index 0) also sets the live count. The count does not move while disabled.
- R4: The prescale code sets the tick rate:
  - 00 steps the count on every clock.
  - 01 steps it every 16 clocks.
  - 10 and 11 step it every 256 clocks.
  - The first tick falls one full prescale period after the enabling write.
- R5: A start value N of at least 1 gives an expiry every N ticks. In periodic mode, after t ticks the count reads N − (t mod N), because it reloads from the start value at each expiry.
- R6: In single-shot mode (bit 6 = 0) the count reaches 0 after N ticks and stays there. The interrupt is set and the enable bit clears itself.
- R7: The interrupt stays high until a write of any data to index 3. After that write it is low, unless an expiry occurs in the same cycle, in which case the expiry wins.
- R8: Clearing the enable bit freezes the count and keeps the periodic and prescale bits. Setting it again resumes counting from the frozen value.
- R9: A start-value write while the timer runs leaves the current count untouched. The new value is used at the next reload.
- R10: Index 4 reads the interrupt state on bit 0, with zeros above it.
- R11: Writes to index 1 (count) and index 4 (status) have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write when high, together with bus_sel |
| bus_addr | input | 5 | Byte address; bits 4:2 select the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 1 | Level interrupt |

## Verification
The count is read combinationally, so a wrong counter or prescaler state shows up on the very next count read. Comparing each sample with N − (t mod N), or with the single-shot value, pins any error to a single tick. A wrong prescaler phase shifts the first step by whole clock periods, so it is caught by sampling one clock on each side of the first expected tick. A lost or stuck interrupt flag appears on `irq` and on the status register in the cycle after the expiry or clear.

// File: rtl/down_timer.sv
module down_timer #(
  parameter int CNT_W = 16,
  parameter int PRE_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [4:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq
);
  localparam logic [2:0] IDX_LOAD = 3'd0;
  localparam logic [2:0] IDX_CNT  = 3'd1;
  localparam logic [2:0] IDX_CTRL = 3'd2;
  localparam logic [2:0] IDX_CLR  = 3'd3;
  localparam logic [2:0] IDX_STAT = 3'd4;

  logic [CNT_W-1:0] load_q, count_q;
  logic [PRE_W-1:0] pre_q, pre_lim;
  logic             en_q, per_q, irq_q;
  logic [1:0]       psc_q;

  wire [2:0] idx      = bus_addr[4:2];
  wire       wsel     = bus_sel & bus_wr;
  wire       wr_load  = wsel && idx == IDX_LOAD;
  wire       wr_ctrl  = wsel && idx == IDX_CTRL;
  wire       wr_clr   = wsel && idx == IDX_CLR;

  always_comb begin
    case (psc_q)
      2'b00:   pre_lim = '0;
      2'b01:   pre_lim = PRE_W'(15);
      default: pre_lim = PRE_W'(255);
    endcase
  end

  wire tick   = en_q && (pre_q >= pre_lim);
  wire expire = tick && (count_q <= CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pre_q <= '0;
    else if (!en_q)      pre_q <= '0;
    else if (tick)       pre_q <= '0;
    else                 pre_q <= pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       load_q <= '0;
    else if (wr_load) load_q <= bus_wdata[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                count_q <= '0;
    else if (expire)           count_q <= per_q ? load_q : '0;
    else if (tick)             count_q <= count_q - 1'b1;
    else if (wr_load && !en_q) count_q <= bus_wdata[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      per_q <= 1'b0;
      psc_q <= 2'b00;
    end else if (wr_ctrl) begin
      en_q  <= bus_wdata[7];
      per_q <= bus_wdata[6];
      psc_q <= bus_wdata[3:2];
    end else if (expire && !per_q) begin
      en_q  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      irq_q <= 1'b0;
    else if (expire) irq_q <= 1'b1;
    else if (wr_clr) irq_q <= 1'b0;
  end

  assign irq = irq_q;

  always_comb begin
    case (idx)
      IDX_LOAD: bus_rdata = 32'(load_q);
      IDX_CNT:  bus_rdata = 32'(count_q);
      IDX_CTRL: bus_rdata = {24'd0, en_q, per_q, 2'b00, psc_q, 2'b00};
      IDX_STAT: bus_rdata = {31'd0, irq_q};
      default:  bus_rdata = '0;
    endcase
  end

  // R3
  load_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_load && !en_q) |=> (count_q == $past(bus_wdata[CNT_W-1:0])));

  // R8
  frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !wr_load) |=> $stable(count_q));

  // R6
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !per_q && !wr_ctrl) |=> (!en_q && count_q == '0 && irq_q));

  // R7
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !wr_clr) |=> irq_q);

  // R7
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr && !expire) |=> !irq_q);

  // R4
  pre_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_q) |-> (pre_q == '0));
endmodule

// File: tb/down_timer_tb.sv
`timescale 1ns/1ps
module down_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  down_timer dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  localparam logic [4:0] A_LOAD = 5'h00, A_CNT = 5'h04, A_CTRL = 5'h08,
                         A_CLR = 5'h0C, A_STAT = 5'h10;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  function automatic logic [31:0] exp_cnt(input int n, input bit per, input int t);
    if (per) return 32'(n - (t % n));
    return (t >= n) ? 32'd0 : 32'(n - t);
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(A_CTRL, v); chk("R1 ctrl", v, 0);
    rd(A_CNT, v);  chk("R1 count", v, 0);
    chk("R1 irq", {31'd0, irq}, 0);

    // R2 control readback
    wr(A_CTRL, 32'hFF);
    rd(A_CTRL, v); chk("R2 ctrl bits", v, 32'hCC);
    wr(A_CTRL, 32'h44);
    rd(A_CTRL, v); chk("R2 ctrl disabled", v, 32'h44);
    wr(A_CTRL, 0);
    wr(A_CLR, 0);

    // R3 load while disabled, frozen count
    wr(A_LOAD, 32'h1234);
    rd(A_CNT, v); chk("R3 load sets count", v, 32'h1234);
    repeat (10) @(posedge clk);
    @(negedge clk);
    rd(A_CNT, v); chk("R3 no count while disabled", v, 32'h1234);

    // R11 writes to count and status are ignored
    wr(A_CNT, 32'h5555);
    wr(A_STAT, 32'h1);
    rd(A_CNT, v);  chk("R11 count write ignored", v, 32'h1234);
    rd(A_STAT, v); chk("R11 status write ignored", v, 0);

    // R4 divide by 16 and 256
    wr(A_LOAD, 3);
    wr(A_CTRL, 32'hC4);
    repeat (15) @(posedge clk); @(negedge clk);
    rd(A_CNT, v); chk("R4 /16 before tick", v, 3);
    @(posedge clk); @(negedge clk);
    rd(A_CNT, v); chk("R4 /16 first tick", v, 2);
    wr(A_CTRL, 0);
    wr(A_LOAD, 3);
    wr(A_CTRL, 32'hC8);
    repeat (255) @(posedge clk); @(negedge clk);
    rd(A_CNT, v); chk("R4 /256 before tick", v, 3);
    @(posedge clk); @(negedge clk);
    rd(A_CNT, v); chk("R4 /256 first tick", v, 2);
    wr(A_CTRL, 0);
    wr(A_CLR, 0);

    // R6 single-shot
    wr(A_LOAD, 5);
    wr(A_CTRL, 32'h80);
    repeat (4) @(posedge clk); @(negedge clk);
    rd(A_STAT, v); chk("R6 no irq before expiry", v, 0);
    @(posedge clk); @(negedge clk);
    rd(A_CNT, v);  chk("R6 count zero", v, 0);
    rd(A_CTRL, v); chk("R6 enable self-cleared", v, 0);
    rd(A_STAT, v); chk("R10 status follows irq", v, 1);
    repeat (10) @(posedge clk); @(negedge clk);
    rd(A_CNT, v);  chk("R6 stays at zero", v, 0);
    // R7 hold and clear
    chk("R7 irq held", {31'd0, irq}, 1);
    wr(A_CLR, 32'hDEAD);
    chk("R7 irq cleared", {31'd0, irq}, 0);
    rd(A_STAT, v); chk("R10 status cleared", v, 0);

    // R8 disable freezes, keeps mode
    wr(A_LOAD, 100);
    wr(A_CTRL, 32'hC0);
    repeat (10) @(posedge clk); @(negedge clk);
    rd(A_CNT, v); chk("R5 periodic running", v, 90);
    wr(A_CTRL, 32'h40);
    repeat (20) @(posedge clk); @(negedge clk);
    rd(A_CNT, v);  chk("R8 frozen count", v, 88);
    rd(A_CTRL, v); chk("R8 mode kept", v, 32'h40);
    wr(A_CTRL, 32'hC0);
    repeat (5) @(posedge clk); @(negedge clk);
    rd(A_CNT, v); chk("R8 resumes", v, 83);
    wr(A_CTRL, 0);
    wr(A_CLR, 0);

    // R9 load while running
    wr(A_LOAD, 10);
    wr(A_CTRL, 32'hC0);
    wr(A_LOAD, 4);
    repeat (8) @(posedge clk); @(negedge clk);
    rd(A_CNT, v); chk("R9 count undisturbed", v, 1);
    @(posedge clk); @(negedge clk);
    rd(A_CNT, v); chk("R9 new value at reload", v, 4);
    chk("R5 irq on expiry", {31'd0, irq}, 1);
    repeat (4) @(posedge clk); @(negedge clk);
    rd(A_CNT, v); chk("R5 reload again", v, 4);
    wr(A_CTRL, 0);
    wr(A_CLR, 0);

    // R5 R6 random periods, modes and prescales
    for (int i = 0; i < 24; i++) begin
      int n, c, d, t;
      bit per, pdiv;
      n = 1 + int'($urandom_range(0, 199));
      per = 1'($urandom_range(0, 1));
      pdiv = 1'($urandom_range(0, 1));
      d = pdiv ? 16 : 1;
      c = 1 + int'($urandom_range(0, 1999));
      t = c / d;
      wr(A_CTRL, 0);
      wr(A_LOAD, 32'(n));
      wr(A_CLR, 0);
      wr(A_CTRL, {24'd0, 1'b1, per, 2'b00, 1'b0, pdiv, 2'b00});
      repeat (c) @(posedge clk); @(negedge clk);
      rd(A_CNT, v);  chk(per ? "R5 random count" : "R6 random count", v, exp_cnt(n, per, t));
      rd(A_STAT, v); chk("R7 random irq", v, (t >= n) ? 1 : 0);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule